// File: doc/BRIEF.md
# Length-Prefixed Burst SPI Slave

This block is an SPI slave (mode 0: MOSI is sampled on the rising SCLK edge and MISO changes on the falling edge, most significant bit first). It moves bursts of bytes between an SPI master and a byte-wide synchronous memory. Each chip-select frame starts with a four-byte header. The first two bytes hold the 16-bit start address, high byte first. The third byte carries the direction in bit 7 (1 = write, 0 = read) and length bits 14:8 in bits 6:0. The fourth byte holds length bits 7:0. Data bytes follow at once. After each data byte the address steps by one, and exactly the requested number of bytes reach memory.

SCLK, MOSI and CS_n are brought into the system clock domain by a configurable synchronizer, and SCLK edges are detected there. SCLK high and low times must each last at least 8 system clock periods. The control state machine has eight states. IDLE goes to HDR_ADDR_HI when chip select is seen asserted. Each received header byte then advances the machine: HDR_ADDR_HI to HDR_ADDR_LO, then HDR_CTRL, then HDR_LEN_LO. On the length-low byte, HDR_LEN_LO goes to DRAIN if the length is zero, to WRITE for a write, or to READ for a read (issuing the first fetch). WRITE goes to DRAIN when its last counted byte is stored. READ goes to DRAIN on the first byte clocked after its count runs out. DRAIN absorbs any further bytes. From every state, deasserting chip select returns the machine to IDLE.

Memory reads have a one-cycle latency. The read data is placed in the MISO shift register before the next byte starts shifting out.

Top module: `burst_spi_slave`

## Requirements
- R1: Header order is address high, address low, control, length low; control bit 7 = 1 selects write; length is 15 bits {control[6:0], length low}, so lengths above 255 work.
- R2: In a write burst, data byte i is written to start address + i with one `mem_we` pulse carrying `mem_addr` and `mem_wdata`.
- R3: In a read burst, the byte at start address + i appears on MISO, MSB first, as data byte i, starting with the first byte after the header.
- R4: A two-byte access (length 2) transfers the byte at the start address, the most significant one, first.
- R5: The address wraps from 0xFFFF to 0x0000 within a burst.
- R6: Write data bytes beyond the length produce no memory write.
- R7: Read bytes beyond the length shift out as 0x00 and cause no memory read.
- R8: A length of zero causes no memory access in either direction, and MISO stays 0x00.
- R9: Deasserting CS_n ends the burst at once; a partially shifted byte is not written, and the next frame starts with a fresh header.
- R10: MISO is 0 after reset, during the header bytes, and while CS_n is high.
- R11: `mem_we` and `mem_re` are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock from master |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| mem_re | output | 1 | Memory read strobe; data returns next cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one cycle after `mem_re` |

## Verification
The hardest case to reach is a frame cut off mid-byte. The master raises chip select after only five bits of a data byte. The bench must show that this byte never reaches memory and that the shifter starts the next frame aligned to a new header. The stimulus drives a three-byte write with one complete data byte and a truncated second one, then reads both addresses back. The write count and the unchanged second location expose any stray write or misaligned header. The address wrap is reached by starting a burst at 0xFFFE. The upper length bits are exercised by a 259-byte read.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 16;
    localparam int LEN_W  = 15;
    localparam int BIT_CNT_W = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_CTRL,
        ST_LEN_LO,
        ST_WRITE,
        ST_READ,
        ST_DRAIN
    } bsp_state_e;
endpackage

// File: rtl/bsp_sync_edge.sv
module bsp_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic mosi,
    input  logic cs_n,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic mosi_s,
    output logic active
);
    logic [STAGES-1:0] sclk_sh;
    logic [STAGES-1:0] mosi_sh;
    logic [STAGES-1:0] csn_sh;
    logic              sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_sh <= '0;
            mosi_sh <= '0;
            csn_sh  <= '1;
            sclk_d  <= 1'b0;
        end else begin
            sclk_sh <= {sclk_sh[STAGES-2:0], sclk};
            mosi_sh <= {mosi_sh[STAGES-2:0], mosi};
            csn_sh  <= {csn_sh[STAGES-2:0], cs_n};
            sclk_d  <= sclk_sh[STAGES-1];
        end
    end

    assign sclk_rise = sclk_sh[STAGES-1] & ~sclk_d;
    assign sclk_fall = ~sclk_sh[STAGES-1] & sclk_d;
    assign mosi_s    = mosi_sh[STAGES-1];
    assign active    = ~csn_sh[STAGES-1];
endmodule

// File: rtl/bsp_shifter.sv
module bsp_shifter
    import bsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              mosi_s,
    input  logic              tx_load,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_data,
    output logic              miso
);
    logic [BIT_CNT_W-1:0] bit_cnt_q;
    logic [BYTE_W-2:0]    rx_q;
    logic [BYTE_W-1:0]    tx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            rx_q      <= '0;
            tx_q      <= '0;
            byte_vld  <= 1'b0;
            byte_data <= '0;
        end else if (!active) begin
            // frame closed: any partial byte is dropped
            bit_cnt_q <= '0;
            rx_q      <= '0;
            tx_q      <= '0;
            byte_vld  <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            if (sclk_rise) begin
                rx_q      <= {rx_q[BYTE_W-3:0], mosi_s};
                bit_cnt_q <= bit_cnt_q + 1'b1;
                if (bit_cnt_q == BIT_CNT_W'(BYTE_W-1)) begin
                    byte_data <= {rx_q, mosi_s};
                    byte_vld  <= 1'b1;
                end
            end
            if (tx_load) begin
                tx_q <= tx_data;
            end else if (sclk_fall && bit_cnt_q != '0) begin
                tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
            end
        end
    end

    assign miso = tx_q[BYTE_W-1];

    p_idle_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (bit_cnt_q == '0 && !byte_vld));
    p_miso_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !miso);
    p_byte_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld);
endmodule

// File: rtl/bsp_ctrl.sv
module bsp_ctrl
    import bsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              tx_load,
    output logic [BYTE_W-1:0] tx_data
);
    bsp_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic              wr_q, wr_d;
    logic [LEN_W-BYTE_W-1:0] len_hi_q, len_hi_d;
    logic [LEN_W-1:0]  cnt_q, cnt_d;
    logic              rd_pend_q;
    logic [LEN_W-1:0]  len_full;

    assign len_full = {len_hi_q, byte_data};

    // outputs
    always_comb begin
        mem_re = byte_vld &&
                 ((state_q == ST_LEN_LO && !wr_q && len_full != '0) ||
                  (state_q == ST_READ && cnt_q != '0));
        mem_we    = byte_vld && (state_q == ST_WRITE);
        mem_addr  = addr_q;
        mem_wdata = byte_data;
        tx_load   = rd_pend_q ||
                    (byte_vld && ((state_q == ST_READ && cnt_q == '0) ||
                                  state_q == ST_DRAIN));
        tx_data   = rd_pend_q ? mem_rdata : '0;
    end

    // next state
    always_comb begin
        state_d  = state_q;
        addr_d   = addr_q;
        wr_d     = wr_q;
        len_hi_d = len_hi_q;
        cnt_d    = cnt_q;
        unique case (state_q)
            ST_IDLE: if (active) state_d = ST_ADDR_HI;
            ST_ADDR_HI: if (byte_vld) begin
                addr_d[ADDR_W-1:BYTE_W] = byte_data;
                state_d = ST_ADDR_LO;
            end
            ST_ADDR_LO: if (byte_vld) begin
                addr_d[BYTE_W-1:0] = byte_data;
                state_d = ST_CTRL;
            end
            ST_CTRL: if (byte_vld) begin
                wr_d     = byte_data[BYTE_W-1];
                len_hi_d = byte_data[LEN_W-BYTE_W-1:0];
                state_d  = ST_LEN_LO;
            end
            ST_LEN_LO: if (byte_vld) begin
                if (len_full == '0) begin
                    state_d = ST_DRAIN;
                end else if (wr_q) begin
                    cnt_d   = len_full;
                    state_d = ST_WRITE;
                end else begin
                    cnt_d   = len_full - 1'b1;
                    addr_d  = addr_q + 1'b1;
                    state_d = ST_READ;
                end
            end
            ST_WRITE: if (byte_vld) begin
                addr_d = addr_q + 1'b1;
                cnt_d  = cnt_q - 1'b1;
                if (cnt_q == LEN_W'(1)) state_d = ST_DRAIN;
            end
            ST_READ: if (byte_vld) begin
                if (cnt_q != '0) begin
                    addr_d = addr_q + 1'b1;
                    cnt_d  = cnt_q - 1'b1;
                end else begin
                    state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: state_d = ST_DRAIN;
            default:  state_d = ST_IDLE;
        endcase
        if (!active) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            addr_q    <= '0;
            wr_q      <= 1'b0;
            len_hi_q  <= '0;
            cnt_q     <= '0;
            rd_pend_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            addr_q    <= addr_d;
            wr_q      <= wr_d;
            len_hi_q  <= len_hi_d;
            cnt_q     <= cnt_d;
            rd_pend_q <= mem_re && active;
        end
    end

    p_access_framed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> active);
    p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !mem_re);
    p_drain_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN) |-> !(mem_we || mem_re));
    p_addr_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we || mem_re) && addr_q == '1) |=> (addr_q == '0));
endmodule

// File: rtl/burst_spi_slave.sv
module burst_spi_slave
    import bsp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              mem_re,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata
);
    logic              sclk_rise, sclk_fall, mosi_s, active;
    logic              byte_vld, tx_load;
    logic [BYTE_W-1:0] byte_data, tx_data;

    bsp_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .mosi_s(mosi_s), .active(active)
    );

    bsp_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .active(active),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_s(mosi_s),
        .tx_load(tx_load), .tx_data(tx_data),
        .byte_vld(byte_vld), .byte_data(byte_data), .miso(spi_miso)
    );

    bsp_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .active(active),
        .byte_vld(byte_vld), .byte_data(byte_data), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .tx_load(tx_load), .tx_data(tx_data)
    );
endmodule

// File: tb/sim_burst_spi_slave.sv
module sim_burst_spi_slave;
    localparam int HALF = 10;
    typedef logic [7:0] bq_t[$];
    typedef struct { logic [15:0] a; logic [7:0] d; } wr_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1;
    logic miso, mem_re, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;

    always #5 clk = ~clk;

    burst_spi_slave u0 (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .mem_re(mem_re), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    int n_chk = 0, n_fail = 0, rd_events = 0, wr_events = 0;
    logic [7:0] mem [int];
    wr_t exp_wr[$];

    function automatic logic [7:0] seed(int a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] mget(int a);
        if (mem.exists(a)) return mem[a];
        return seed(a);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_re) mem_rdata <= mget(int'(mem_addr));
        if (mem_we) mem[int'(mem_addr)] = mem_wdata;
    end

    // monitor: pops expected writes as the design issues them
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_re || mem_we)
                check(!(mem_re && mem_we), "R11 exclusive strobes", {mem_re, mem_we}, 1);
            if (mem_re) rd_events++;
            if (mem_we) begin
                wr_t e;
                wr_events++;
                if (exp_wr.size() == 0) begin
                    check(1'b0, "R6 unexpected write", {mem_addr, mem_wdata}, 0);
                end else begin
                    e = exp_wr.pop_front();
                    check(mem_addr == e.a && mem_wdata == e.d, "R2 write addr/data",
                          {mem_addr, mem_wdata}, {e.a, e.d});
                end
            end
        end
    end

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx, input int nbits);
        rx = 8'h00;
        for (int i = 7; i >= 8 - nbits; i--) begin
            mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = miso;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic frame(input logic [15:0] a, input bit wr, input logic [14:0] len,
                         input bq_t dq, input int extra, input string req);
        logic [7:0] hdr [4];
        logic [7:0] r;
        bq_t exp_rx;
        int nd, r0, w0;
        hdr[0] = a[15:8];
        hdr[1] = a[7:0];
        hdr[2] = {wr, len[14:8]};
        hdr[3] = len[7:0];
        nd = (wr ? dq.size() : int'(len)) + extra;
        for (int i = 0; i < nd; i++) begin
            if (wr && i < int'(len) && i < dq.size())
                exp_wr.push_back('{a: 16'(a + i), d: dq[i]});
            if (!wr) exp_rx.push_back(i < int'(len) ? mget(int'(16'(a + i))) : 8'h00);
        end
        r0 = rd_events;
        w0 = wr_events;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int h = 0; h < 4; h++) begin
            spi_byte(hdr[h], r, 8);
            check(r == 8'h00, "R10 header miso", r, 0);
        end
        for (int i = 0; i < nd; i++) begin
            spi_byte((wr && i < dq.size()) ? dq[i] : 8'hFF, r, 8);
            if (!wr) check(r == exp_rx[i], req, r, exp_rx[i]);
        end
        cs_n = 1'b1;
        repeat (4 * HALF) @(negedge clk);
        check(exp_wr.size() == 0, req, exp_wr.size(), 0);
        if (wr) check(wr_events - w0 == ((dq.size() < int'(len)) ? dq.size() : int'(len)),
                      req, wr_events - w0, len);
        else    check(rd_events - r0 == int'(len), req, rd_events - r0, len);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(miso == 1'b0, "R10 reset miso", miso, 0);
        check(!mem_we && !mem_re, "R10 reset strobes", {mem_we, mem_re}, 0);

        // R1 R2: plain write burst
        frame(16'h1234, 1'b1, 15'd4, '{8'h11, 8'h22, 8'h33, 8'h44}, 0, "R2 write burst");
        // R3 R7: read back with two excess bytes
        frame(16'h1234, 1'b0, 15'd4, '{}, 2, "R3 R7 read burst");
        // R4: two-byte value, MSB at start address
        frame(16'h0200, 1'b1, 15'd2, '{8'hAB, 8'hCD}, 0, "R4 two-byte write");
        frame(16'h0200, 1'b0, 15'd2, '{}, 0, "R4 two-byte read");
        // R5: wrap from 0xFFFF to 0x0000
        frame(16'hFFFE, 1'b1, 15'd3, '{8'h01, 8'h02, 8'h03}, 0, "R5 wrap write");
        frame(16'hFFFF, 1'b0, 15'd2, '{}, 0, "R5 wrap read");
        // R6: excess write bytes ignored, confirmed by readback
        frame(16'h0300, 1'b1, 15'd1, '{8'h77, 8'h88, 8'h99}, 0, "R6 excess write");
        frame(16'h0300, 1'b0, 15'd3, '{}, 0, "R6 readback");
        // R8: zero length in both directions
        frame(16'h0500, 1'b1, 15'd0, '{8'hEE, 8'hDD}, 0, "R8 zero write");
        frame(16'h0500, 1'b0, 15'd0, '{}, 3, "R8 zero read");

        // R9: abort in mid-byte
        begin
            int w0;
            w0 = wr_events;
            exp_wr.push_back('{a: 16'h0400, d: 8'h5A});
            cs_n = 1'b0;
            repeat (HALF) @(negedge clk);
            spi_byte(8'h04, r, 8);
            spi_byte(8'h00, r, 8);
            spi_byte(8'h80, r, 8);
            spi_byte(8'h03, r, 8);
            spi_byte(8'h5A, r, 8);
            spi_byte(8'hC3, r, 5);
            cs_n = 1'b1;
            repeat (4 * HALF) @(negedge clk);
            check(wr_events - w0 == 1, "R9 abort write count", wr_events - w0, 1);
            check(miso == 1'b0, "R10 miso after frame", miso, 0);
        end
        frame(16'h0400, 1'b0, 15'd2, '{}, 0, "R9 fresh header readback");

        // R1: length with upper bits set (259 bytes)
        frame(16'h1000, 1'b0, 15'h0103, '{}, 1, "R1 long read");

        summary();
        $finish;
    end
endmodule